// File: doc/BRIEF.md
# Priority Interrupt Controller with Alternate Vector Table

This block gathers a set of interrupt sources and decides, once per instruction cycle, whether the processor should be interrupted. Each source owns a pending flag, an enable bit and a 3-bit priority level. The lowest-numbered sources are external pins. Each pin has an edge detector, and a per-pin polarity bit selects the rising or the falling edge. The other sources set their flags through single-cycle set pulses. Software clears flags by writing ones to the clear port.

On each instruction-cycle strobe the enabled pending flags are captured. During the following clock the captured requests are arbitrated. The winner is taken only when its priority is strictly above the current processor priority level. A taken interrupt produces a one-cycle pulse carrying the vector address and the source number, and loads the winner's priority as the new processor level. A single select input moves every vector lookup from the default table to an alternate table of the same layout, placed directly after it. When the processor is in sleep or idle, a wake-up output pulses together with the interrupt.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Enabled pending flags are captured only at a clock edge where `cyc_start` is 1. A flag that becomes set after that edge has no effect on the decision made for that strobe.
- R2: A set event raises the source's flag, and the flag stays 1 until a 1 is written to its bit of `flag_clr`. If a set event and a clear arrive in the same cycle, the set wins.
- R3: A captured flag whose `irq_en` bit is 0 never causes an interrupt.
- R4: An interrupt is taken only when the winning priority is strictly greater than `cpu_ipl`. A winner whose priority is equal to or lower than `cpu_ipl` is rejected, and `cpu_ipl` stays unchanged.
- R5: The captured request with the highest priority wins. When priorities are equal, the lower source index wins.
- R6: Taking an interrupt loads the winner's priority into `cpu_ipl`. Otherwise `ipl_wr` loads `ipl_wdata`. If both happen at the same edge, the taken interrupt wins.
- R7: The vector is VEC_BASE + index when `alt_sel` is 0, and VEC_BASE + NSRC + index when `alt_sel` is 1. With the defaults (VEC_BASE=4, NSRC=16) this gives 4+i and 20+i.
- R8: External pin i (i < NEXT) sets flag i on a rising edge when `ext_pol[i]` is 0 and on a falling edge when `ext_pol[i]` is 1. An edge in the other direction sets nothing.
- R9: `wake` pulses in the same cycle as `irq_take` if `sleep_mode` was 1 when the decision was made, and it is never 1 without `irq_take`.
- R10: `irq_take` is a one-cycle pulse that appears at the second clock edge of a strobe: the edge after the capture edge.
- R11: After reset, all flags, `cpu_ipl`, `irq_take` and `wake` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | Instruction-cycle strobe; captures enabled flags |
| src_set | input | NSRC | Single-cycle set pulses, one per source |
| ext_pin | input | NEXT | External request pins (sources 0..NEXT-1) |
| ext_pol | input | NEXT | Edge select per pin: 0 rising, 1 falling |
| flag_clr | input | NSRC | Write-1-to-clear for the pending flags |
| irq_en | input | NSRC | Per-source enable |
| prio_flat | input | 3*NSRC | Priority of source i in bits [3i+2:3i] |
| ipl_wr | input | 1 | Software write strobe for the processor level |
| ipl_wdata | input | 3 | Value written to the processor level |
| alt_sel | input | 1 | 1 selects the alternate vector table |
| sleep_mode | input | 1 | Processor is in sleep or idle |
| pend_flags | output | NSRC | Pending flags |
| cpu_ipl | output | 3 | Current processor priority level |
| irq_take | output | 1 | One-cycle interrupt pulse |
| irq_vec | output | VW | Vector address of the taken interrupt |
| irq_src | output | $clog2(NSRC) | Source index of the taken interrupt |
| wake | output | 1 | Wake-up pulse for sleep or idle |

## Verification
The bench presents a request whose priority equals the processor level and one whose priority is below it. A design that compared with greater-or-equal would take the first and so re-enter its own level, and a design that ignored the level would take both. Two requests of equal priority are posted together: a wrong tie-break returns the higher index's vector. A flag is raised just after the capture edge: a design that arbitrated live flags would take it one strobe early. The bench also writes the processor level on the same edge as an acceptance, drives edges of both polarities on two pins and toggles the table select. These catch a write that overrides the new level, an inverted polarity and a wrong alternate base.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC     = 16,
  parameter int NEXT     = 5,
  parameter int VW       = 16,
  parameter int VEC_BASE = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cyc_start,
  input  logic [NSRC-1:0]          src_set,
  input  logic [NEXT-1:0]          ext_pin,
  input  logic [NEXT-1:0]          ext_pol,
  input  logic [NSRC-1:0]          flag_clr,
  input  logic [NSRC-1:0]          irq_en,
  input  logic [3*NSRC-1:0]        prio_flat,
  input  logic                     ipl_wr,
  input  logic [2:0]               ipl_wdata,
  input  logic                     alt_sel,
  input  logic                     sleep_mode,
  output logic [NSRC-1:0]          pend_flags,
  output logic [2:0]               cpu_ipl,
  output logic                     irq_take,
  output logic [VW-1:0]            irq_vec,
  output logic [$clog2(NSRC)-1:0]  irq_src,
  output logic                     wake
);
  localparam int IW = $clog2(NSRC);
  localparam logic [VW-1:0] DEF_BASE = VW'(VEC_BASE);
  localparam logic [VW-1:0] ALT_BASE = VW'(VEC_BASE + NSRC);

  logic [NEXT-1:0] pin_q;
  logic [NSRC-1:0] set_ev;
  logic [NSRC-1:0] samp;
  logic            samp_v;
  logic            win_ok;
  logic [IW-1:0]   win_idx;
  logic [2:0]      win_lvl;
  logic            accept;

  for (genvar g = 0; g < NSRC; g++) begin : g_set
    if (g < NEXT) begin : g_ext
      assign set_ev[g] = src_set[g] |
        (ext_pol[g] ? (pin_q[g] & ~ext_pin[g]) : (~pin_q[g] & ext_pin[g]));
    end else begin : g_int
      assign set_ev[g] = src_set[g];
    end
  end

  always_comb begin
    win_ok  = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (samp[i] && (!win_ok || prio_flat[3*i +: 3] >= win_lvl)) begin
        win_ok  = 1'b1;
        win_idx = IW'(i);
        win_lvl = prio_flat[3*i +: 3];
      end
    end
  end

  assign accept = samp_v && win_ok && (win_lvl > cpu_ipl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q      <= '0;
      pend_flags <= '0;
      samp       <= '0;
      samp_v     <= 1'b0;
      cpu_ipl    <= '0;
      irq_take   <= 1'b0;
      irq_vec    <= '0;
      irq_src    <= '0;
      wake       <= 1'b0;
    end else begin
      pin_q      <= ext_pin;
      pend_flags <= (pend_flags & ~flag_clr) | set_ev;
      samp_v     <= cyc_start;
      if (cyc_start) samp <= pend_flags & irq_en;
      irq_take   <= accept;
      wake       <= accept & sleep_mode;
      if (accept) begin
        irq_vec <= (alt_sel ? ALT_BASE : DEF_BASE) + VW'(win_idx);
        irq_src <= win_idx;
        cpu_ipl <= win_lvl;
      end else if (ipl_wr) begin
        cpu_ipl <= ipl_wdata;
      end
    end
  end

  assert_no_stray_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_flags & ~$past(pend_flags) & ~$past(set_ev)) == '0);

  assert_level_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (cpu_ipl > $past(cpu_ipl)));

  assert_take_after_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> $past(samp_v));

  assert_table_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> ((irq_vec >= ALT_BASE) == $past(alt_sel)));

  assert_wake_only_with_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> irq_take);

  assert_wake_follows_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (wake == $past(sleep_mode)));
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int NSRC = 16;
  localparam int NEXT = 5;
  localparam int VW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 1'b0;
  logic [NSRC-1:0] src_set = '0, flag_clr = '0, irq_en = '1;
  logic [NEXT-1:0] ext_pin = '0, ext_pol = '0;
  logic [2:0] prio [NSRC];
  logic [3*NSRC-1:0] prio_flat;
  logic ipl_wr = 1'b0;
  logic [2:0] ipl_wdata = '0;
  logic alt_sel = 1'b0, sleep_mode = 1'b0;
  logic [NSRC-1:0] pend_flags;
  logic [2:0] cpu_ipl;
  logic irq_take, wake;
  logic [VW-1:0] irq_vec;
  logic [3:0] irq_src;

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < NSRC; i++) prio_flat[3*i +: 3] = prio[i];

  prio_irq_ctrl #(.NSRC(NSRC), .NEXT(NEXT), .VW(VW), .VEC_BASE(4)) i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .src_set(src_set),
    .ext_pin(ext_pin), .ext_pol(ext_pol), .flag_clr(flag_clr), .irq_en(irq_en),
    .prio_flat(prio_flat), .ipl_wr(ipl_wr), .ipl_wdata(ipl_wdata), .alt_sel(alt_sel),
    .sleep_mode(sleep_mode), .pend_flags(pend_flags), .cpu_ipl(cpu_ipl),
    .irq_take(irq_take), .irq_vec(irq_vec), .irq_src(irq_src), .wake(wake));

  typedef struct packed {
    logic       take;
    logic [15:0] vec;
    logic [2:0] ipl;
    logic       wake;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int n_cmp = 0, n_bad = 0;
  logic s0 = 1'b0, s1 = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    s0 <= cyc_start;
    s1 <= s0;
  end

  always @(negedge clk) begin
    if (s1) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected result", 1, 0);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " take"}, irq_take, e.take);
        check({t, " ipl"}, cpu_ipl, e.ipl);
        check({t, " wake"}, wake, e.wake);
        if (e.take) check({t, " vec"}, irq_vec, e.vec);
      end
    end else begin
      check("R10 pulse outside window", irq_take, 0);
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input string tag, input logic t, input logic [15:0] v,
                        input logic [2:0] l, input logic w);
    exp_q.push_back('{take: t, vec: v, ipl: l, wake: w});
    tag_q.push_back(tag);
    cyc_start = 1'b1;
    tick();
    cyc_start = 1'b0;
    tick(3);
  endtask

  task automatic set_ipl(input logic [2:0] v);
    ipl_wr = 1'b1; ipl_wdata = v;
    tick();
    ipl_wr = 1'b0;
    tick();
  endtask

  task automatic clr_flags(input logic [NSRC-1:0] m);
    flag_clr = m;
    tick();
    flag_clr = '0;
    tick();
  endtask

  task automatic pulse_set(input logic [NSRC-1:0] m);
    src_set = m;
    tick();
    src_set = '0;
    tick();
  endtask

  initial begin
    #200000;
    check("watchdog expired", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NSRC; i++) prio[i] = 3'd0;
    tick(3);
    rst_n = 1'b1;
    tick();
    check("R11 flags", pend_flags, 0);
    check("R11 ipl", cpu_ipl, 0);
    check("R11 take", irq_take, 0);
    check("R11 wake", wake, 0);

    ext_pin[0] = 1'b1; tick(2);
    check("R8 rising pin0", pend_flags[0], 1);
    clr_flags(16'h0001);
    check("R2 w1c pin0", pend_flags[0], 0);
    ext_pin[0] = 1'b0; tick(2);
    check("R8 falling ignored pin0", pend_flags[0], 0);

    ext_pol[3] = 1'b1; tick();
    ext_pin[3] = 1'b1; tick(2);
    check("R8 rising ignored pin3", pend_flags[3], 0);
    ext_pin[3] = 1'b0; tick(2);
    check("R8 falling pin3", pend_flags[3], 1);

    prio[3] = 3'd5;
    strobe("R5 R7 take src3", 1, 16'd7, 3'd5, 0);
    strobe("R4 equal level rejected", 0, 16'd0, 3'd5, 0);
    check("R2 flag held", pend_flags[3], 1);

    prio[8] = 3'd2;
    pulse_set(16'h0100);
    strobe("R4 lower level rejected", 0, 16'd0, 3'd5, 0);

    set_ipl(3'd1);
    check("R6 software write", cpu_ipl, 1);
    clr_flags(16'h0008);
    irq_en[8] = 1'b0;
    strobe("R3 disabled ignored", 0, 16'd0, 3'd1, 0);
    irq_en[8] = 1'b1;
    alt_sel = 1'b1; sleep_mode = 1'b1;
    strobe("R7 R9 alt table wake", 1, 16'd28, 3'd2, 1);
    alt_sel = 1'b0;
    strobe("R9 no wake without take", 0, 16'd0, 3'd2, 0);
    sleep_mode = 1'b0;

    set_ipl(3'd0);
    clr_flags(16'h0100);
    prio[9] = 3'd4; prio[10] = 3'd6; prio[12] = 3'd6;
    pulse_set(16'h1600);
    strobe("R5 tie lower index", 1, 16'd14, 3'd6, 0);

    set_ipl(3'd0);
    clr_flags('1);
    prio[11] = 3'd7;
    exp_q.push_back('{take: 0, vec: 16'd0, ipl: 3'd0, wake: 0});
    tag_q.push_back("R1 late flag not captured");
    cyc_start = 1'b1;
    tick();
    cyc_start = 1'b0; src_set = 16'h0800;
    tick();
    src_set = '0;
    tick(2);
    check("R2 late flag pending", pend_flags[11], 1);
    strobe("R1 taken next strobe", 1, 16'd15, 3'd7, 0);

    set_ipl(3'd0);
    exp_q.push_back('{take: 1, vec: 16'd15, ipl: 3'd7, wake: 0});
    tag_q.push_back("R6 take beats write");
    cyc_start = 1'b1;
    tick();
    cyc_start = 1'b0; ipl_wr = 1'b1; ipl_wdata = 3'd3;
    tick();
    ipl_wr = 1'b0;
    tick(2);

    src_set = 16'h2000; flag_clr = 16'h2000;
    tick();
    src_set = '0; flag_clr = '0;
    tick();
    check("R2 set beats clear", pend_flags[13], 1);

    tick(2);
    check("R10 queue drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule